// File: doc/BRIEF.md
# Inductor Receiver Switch Sequencer

This block is the digital controller for a non-resonant inductive power receiver. It drives four power switches around a pickup coil: a low-side shorting switch and a high-side drain switch on each of the two coil nodes. In every half cycle the coil is first shorted so that it builds current from the induced voltage. It is then drained into the storage capacitor and shorted again. The edges of an external sync signal set the timing. Comparator flags for the switching nodes gate every switch closure, so that a switch closes only when the voltage across it is near zero.

The drain switch stays closed for a programmable number of clock cycles. This covers draining the coil and then drawing some energy back from the battery to strengthen the coil's damping. A delay of zero turns the drain switch into a diode emulator, which opens when a coil-current-zero flag is seen. A recalibration request also forces diode behaviour. After that drain finishes, the block enters a calibration configuration: the sense switches put the sensing resistor across the coil, and only the negative low-side switch stays closed. The block stays there until the request is withdrawn.

Top module: `coil_switch_seq`

## Requirements
- R1: After reset, and on the clock edge after `en` is sampled low, every gate, sense and calibration output is 0.
- R2: When enabled and idle, the first clock edge that samples `sync_in` high closes both low-side switches (`lo_p_on` = `lo_n_on` = 1).
- R3: The first edge that samples `sync_in` low after it was high opens `lo_p_on`. `lo_n_on` stays 1.
- R4: After the positive low-side switch opens, `hi_p_on` rises only on an edge that samples `node_p_hi` = 1.
- R5: With `dly` = D (1..63) and no recalibration pending, `hi_p_on` stays high for exactly D clock cycles and then opens.
- R6: After the positive drain ends, `lo_p_on` recloses only on an edge that samples `node_p_lo` = 1.
- R7: The negative side runs the same sequence (R3 to R6) starting from a rising edge of `sync_in`, using `node_n_hi`, `node_n_lo`, `hi_n_on` and `lo_n_on`.
- R8: With `dly` = 0 the drain switch stays closed until an edge samples `i_zero` = 1, and then opens.
- R9: A drain that starts while `recal_req` = 1 acts as a diode regardless of `dly`. When it ends on `i_zero`, `cal_active`, `sense_p_on`, `sense_n_on` and `lo_n_on` go to 1, and every other gate goes to 0. This configuration is held while `recal_req` stays 1, whatever `sync_in` does.
- R10: The edge that samples `recal_req` low during calibration clears calibration and opens all switches. Both low-side switches then close on an edge that samples `sync_in` high.
- R11: A low-side gate and the high-side gate of the same node are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces everything open |
| sync_in | input | 1 | Half-cycle sync; high means positive half cycle |
| recal_req | input | 1 | Recalibration request, a level held for the calibration time |
| node_p_hi | input | 1 | Positive node above battery level |
| node_n_hi | input | 1 | Negative node above battery level |
| node_p_lo | input | 1 | Positive node below zero |
| node_n_lo | input | 1 | Negative node below zero |
| i_zero | input | 1 | Coil current has reached zero |
| dly | input | DLY_W | Drain time in clock cycles; 0 selects diode mode |
| lo_p_on | output | 1 | Positive low-side shorting switch gate |
| lo_n_on | output | 1 | Negative low-side shorting switch gate |
| hi_p_on | output | 1 | Positive high-side drain switch gate |
| hi_n_on | output | 1 | Negative high-side drain switch gate |
| sense_p_on | output | 1 | Positive sense switch gate |
| sense_n_on | output | 1 | Negative sense switch gate |
| cal_active | output | 1 | Calibration configuration in force |

## Verification
The bench builds the block with its default delay width of 6 bits. This puts both ends of the timed drain in reach: the one-cycle minimum and the 63-cycle maximum, as well as a middle value. Zero on the same field reaches diode mode. The 6-bit width also lets the bench show that a recalibration request overrides a nonzero delay: the drain outlasts the programmed count, and calibration follows.

// File: rtl/coil_switch_seq.sv
module coil_switch_seq #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_in,
  input  logic             recal_req,
  input  logic             node_p_hi,
  input  logic             node_n_hi,
  input  logic             node_p_lo,
  input  logic             node_n_lo,
  input  logic             i_zero,
  input  logic [DLY_W-1:0] dly,
  output logic             lo_p_on,
  output logic             lo_n_on,
  output logic             hi_p_on,
  output logic             hi_n_on,
  output logic             sense_p_on,
  output logic             sense_n_on,
  output logic             cal_active
);

  localparam int NSIDE = 2;
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  typedef enum logic [2:0] {S_OFF, S_SHORT, S_WAIT_HI, S_DRAIN, S_WAIT_LO} side_t;

  side_t            st   [NSIDE];
  logic [DLY_W-1:0] cnt  [NSIDE];
  logic [NSIDE-1:0] dio;
  logic             cal_q, sync_q, go_cal;
  logic [NSIDE-1:0] trig, hi_f, lo_f;

  assign trig = {sync_in & ~sync_q, ~sync_in & sync_q};
  assign hi_f = {node_n_hi, node_p_hi};
  assign lo_f = {node_n_lo, node_p_lo};

  assign go_cal = recal_req & i_zero &
                  ((st[0] == S_DRAIN && dio[0]) || (st[1] == S_DRAIN && dio[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSIDE; i++) begin
        st[i]  <= S_OFF;
        cnt[i] <= '0;
      end
      dio    <= '0;
      cal_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (!en) begin
        for (int i = 0; i < NSIDE; i++) st[i] <= S_OFF;
        cal_q <= 1'b0;
      end else if (cal_q) begin
        for (int i = 0; i < NSIDE; i++) st[i] <= S_OFF;
        if (!recal_req) cal_q <= 1'b0;
      end else begin
        for (int i = 0; i < NSIDE; i++) begin
          case (st[i])
            S_OFF:     if (sync_in) st[i] <= S_SHORT;
            S_SHORT:   if (trig[i]) st[i] <= S_WAIT_HI;
            S_WAIT_HI: if (hi_f[i]) begin
                         st[i]  <= S_DRAIN;
                         cnt[i] <= dly;
                         dio[i] <= recal_req | (dly == '0);
                       end
            S_DRAIN:   if (dio[i]) begin
                         if (i_zero) st[i] <= S_WAIT_LO;
                       end else begin
                         cnt[i] <= cnt[i] - ONE;
                         if (cnt[i] == ONE) st[i] <= S_WAIT_LO;
                       end
            S_WAIT_LO: if (lo_f[i]) st[i] <= S_SHORT;
            default:   st[i] <= S_OFF;
          endcase
        end
        if (go_cal) begin
          cal_q <= 1'b1;
          for (int i = 0; i < NSIDE; i++) st[i] <= S_OFF;
        end
      end
    end
  end

  assign lo_p_on    = (st[0] == S_SHORT);
  assign lo_n_on    = (st[1] == S_SHORT) | cal_q;
  assign hi_p_on    = (st[0] == S_DRAIN);
  assign hi_n_on    = (st[1] == S_DRAIN);
  assign sense_p_on = cal_q;
  assign sense_n_on = cal_q;
  assign cal_active = cal_q;

endmodule

module coil_switch_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic recal_req,
  input logic node_p_hi,
  input logic node_n_hi,
  input logic i_zero,
  input logic lo_p_on,
  input logic lo_n_on,
  input logic hi_p_on,
  input logic hi_n_on,
  input logic sense_p_on,
  input logic sense_n_on,
  input logic cal_active
);

  // R1
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(lo_p_on || lo_n_on || hi_p_on || hi_n_on || sense_p_on || sense_n_on || cal_active));

  // R4
  hi_p_zvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_p_on) |-> $past(node_p_hi));

  // R7
  hi_n_zvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_n_on) |-> $past(node_n_hi));

  // R9
  cal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) |-> ($past(i_zero) && $past(recal_req)));

  // R9
  cal_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |-> (sense_p_on && sense_n_on && lo_n_on && !lo_p_on && !hi_p_on && !hi_n_on));

  // R11
  node_p_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_p_on && hi_p_on));

  // R11
  node_n_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_n_on && hi_n_on));

endmodule

bind coil_switch_seq coil_switch_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .recal_req(recal_req),
  .node_p_hi(node_p_hi), .node_n_hi(node_n_hi), .i_zero(i_zero),
  .lo_p_on(lo_p_on), .lo_n_on(lo_n_on), .hi_p_on(hi_p_on), .hi_n_on(hi_n_on),
  .sense_p_on(sense_p_on), .sense_n_on(sense_n_on), .cal_active(cal_active)
);

// File: tb/coil_switch_seq_bench.sv
`timescale 1ns/1ps
module coil_switch_seq_bench;
  localparam int DLY_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sync_in = 1'b0, recal_req = 1'b0;
  logic node_p_hi = 1'b0, node_n_hi = 1'b0, node_p_lo = 1'b0, node_n_lo = 1'b0, i_zero = 1'b0;
  logic [DLY_W-1:0] dly = '0;
  logic lo_p_on, lo_n_on, hi_p_on, hi_n_on, sense_p_on, sense_n_on, cal_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  coil_switch_seq #(.DLY_W(DLY_W)) u_coil_switch_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in), .recal_req(recal_req),
    .node_p_hi(node_p_hi), .node_n_hi(node_n_hi), .node_p_lo(node_p_lo), .node_n_lo(node_n_lo),
    .i_zero(i_zero), .dly(dly),
    .lo_p_on(lo_p_on), .lo_n_on(lo_n_on), .hi_p_on(hi_p_on), .hi_n_on(hi_n_on),
    .sense_p_on(sense_p_on), .sense_n_on(sense_n_on), .cal_active(cal_active)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {25'd0, cal_active, sense_n_on, sense_p_on, hi_n_on, hi_p_on, lo_n_on, lo_p_on};
  endfunction

  task automatic excl(string req);
    check(req, int'(lo_p_on && hi_p_on) + int'(lo_n_on && hi_n_on), 0);
  endtask

  task automatic t_reset();
    tick();
    check("R1 reset", outs(), 0);
    rst_n = 1'b1;
    tick();
    check("R1 disabled", outs(), 0);
  endtask

  task automatic t_energize();
    sync_in = 1'b1;
    tick(); tick();
    check("R1 en low with sync high", outs(), 0);
    en = 1'b1;
    tick();
    check("R2 both low-side closed", outs(), 7'b0000011);
  endtask

  task automatic t_pos_half(int d);
    int n;
    sync_in = 1'b0;
    tick();
    check("R3 lo_p opens, lo_n held", outs(), 7'b0000010);
    tick(); tick();
    check("R4 hi_p waits for flag", int'(hi_p_on), 0);
    node_p_hi = 1'b1;
    tick();
    node_p_hi = 1'b0;
    check("R4 hi_p closes on flag", int'(hi_p_on), 1);
    excl("R11 pos drain");
    n = 0;
    while (hi_p_on && n < 100) begin n++; tick(); end
    check("R5 drain length", n, d);
    tick(); tick();
    check("R6 lo_p waits for flag", int'(lo_p_on), 0);
    node_p_lo = 1'b1;
    tick();
    node_p_lo = 1'b0;
    check("R6 lo_p recloses", outs(), 7'b0000011);
  endtask

  task automatic t_neg_half(int d);
    int n;
    sync_in = 1'b1;
    tick();
    check("R7 lo_n opens on rise", outs(), 7'b0000001);
    tick();
    check("R7 hi_n waits", int'(hi_n_on), 0);
    node_n_hi = 1'b1;
    tick();
    node_n_hi = 1'b0;
    check("R7 hi_n closes on flag", int'(hi_n_on), 1);
    excl("R11 neg drain");
    n = 0;
    while (hi_n_on && n < 100) begin n++; tick(); end
    check("R7 neg drain length", n, d);
    tick();
    check("R7 lo_n waits", int'(lo_n_on), 0);
    node_n_lo = 1'b1;
    tick();
    node_n_lo = 1'b0;
    check("R7 lo_n recloses", outs(), 7'b0000011);
  endtask

  task automatic t_diode();
    dly = '0;
    sync_in = 1'b0;
    tick();
    node_p_hi = 1'b1;
    tick();
    node_p_hi = 1'b0;
    for (int k = 0; k < 6; k++) tick();
    check("R8 diode holds until zero", int'(hi_p_on), 1);
    i_zero = 1'b1;
    tick();
    i_zero = 1'b0;
    check("R8 diode opens on zero", int'(hi_p_on), 0);
    check("R8 no calibration", int'(cal_active), 0);
    node_p_lo = 1'b1;
    tick();
    node_p_lo = 1'b0;
    check("R6 after diode", int'(lo_p_on), 1);
  endtask

  task automatic t_recal();
    dly = 6'd4;
    recal_req = 1'b1;
    sync_in = 1'b0;
    tick();
    node_p_hi = 1'b1;
    tick();
    node_p_hi = 1'b0;
    for (int k = 0; k < 10; k++) tick();
    check("R9 drain outlasts delay", int'(hi_p_on), 1);
    i_zero = 1'b1;
    tick();
    i_zero = 1'b0;
    check("R9 calibration config", outs(), 7'b1110010);
    sync_in = 1'b1; tick(); sync_in = 1'b0; tick(); tick();
    check("R9 held through sync", outs(), 7'b1110010);
    recal_req = 1'b0;
    tick();
    check("R10 leaves calibration", outs(), 0);
    tick();
    check("R10 waits for sync high", outs(), 0);
    sync_in = 1'b1;
    tick();
    check("R10 low-side close on sync", outs(), 7'b0000011);
  endtask

  task automatic t_disable_mid();
    dly = 6'd20;
    sync_in = 1'b0;
    tick();
    node_p_hi = 1'b1;
    tick();
    node_p_hi = 1'b0;
    en = 1'b0;
    tick();
    check("R1 disable mid drain", outs(), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_energize();
    dly = 6'd1;  t_pos_half(1);  t_neg_half(1);
    dly = 6'd5;  t_pos_half(5);  t_neg_half(5);
    dly = 6'd63; t_pos_half(63); t_neg_half(63);
    sync_in = 1'b1; tick();
    t_diode();
    sync_in = 1'b1; tick();
    t_recal();
    t_disable_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule